// File: doc/BRIEF.md
# Cascaded Per-Pad Function Multiplexer

This block sits between 32 general-purpose pads and the on-chip functions that share them. Each pad has three routed paths: the value driven onto the pad, its drive enable, and the value sampled from it. Each path runs through a chain of per-bit two-way stages, one stage per function level. On the drive side, the first-alternate stage picks between the first and second alternate functions. The main stage then picks between the main function and that result. On the sample side the pad value goes the other way: the main stage either hands it to the main function or passes it onward, and the first-alternate and second-alternate stages do the same further down the chain.

At every sample-side stage, the function input that is not given the pad value is tied to a defined level and never left floating. For the main and first-alternate stages this level comes from a programmable default word. A small register port with a single-cycle write strobe holds all select and default words, one bit per pad. Routing is combinational from the stored words, so a new setting is in force from the clock edge that stores it.

Top module: `pinmux_cascade`

## Requirements
- R1: After reset every stored word reads 0. The pads then carry the main function's value and enable, the main function input equals the pad input, and the first-, second- and third-alternate inputs are all 0.
- R2: For each pad n, if bit n of the main drive select (address 0x870) is 0, pad_out[n] equals fn_main_out[n]; if it is 1, pad_out[n] equals the first-alternate drive stage result.
- R3: The first-alternate drive stage result for pad n is fn_alt1_out[n] when bit n of the first-alternate drive select (address 0x890) is 0, and fn_alt2_out[n] when that bit is 1.
- R4: The drive enable is routed in the same two-stage way. The main enable select (0x878) picks fn_main_oe or the first-alternate result, and the first-alternate enable select (0x898) picks fn_alt1_oe (bit 0) or fn_alt2_oe (bit 1).
- R5: Main sample stage (select 0x868, default 0x088). If bit n is 0, fn_main_in[n] equals pad_in[n] and the onward leg carries default bit n. If bit n is 1, fn_main_in[n] equals default bit n and the onward leg carries pad_in[n].
- R6: First-alternate sample stage (select 0x888, default 0x8A0) acts on the onward leg from the main stage. If bit n is 0, fn_alt1_in[n] takes that leg and the next leg carries default bit n. If bit n is 1, fn_alt1_in[n] equals default bit n and the next leg carries the incoming leg.
- R7: Second-alternate sample stage (select 0x8A8) acts on the leg from the first-alternate stage. If bit n is 0, that leg goes to fn_alt2_in[n] and fn_alt3_in[n] is 0. If bit n is 1, the leg goes to fn_alt3_in[n] and fn_alt2_in[n] is 0.
- R8: The nine words sit at byte addresses 0x868, 0x870, 0x878, 0x088, 0x888, 0x890, 0x898, 0x8A0 and 0x8A8. Each one stores and reads back a full 32-bit value independently of the others.
- R9: A write with reg_wr high stores reg_wdata at the rising edge. Routing does not change before that edge and shows the new word right after it.
- R10: reg_rdata shows, one cycle later, the word at the address presented. An unmapped address reads 0, and a write to an unmapped address changes no stored word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Single-cycle write strobe |
| reg_addr | input | 12 | Byte address for write and read |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data |
| fn_main_out | input | 32 | Main function pad value |
| fn_main_oe | input | 32 | Main function drive enable |
| fn_alt1_out | input | 32 | First alternate pad value |
| fn_alt1_oe | input | 32 | First alternate drive enable |
| fn_alt2_out | input | 32 | Second alternate pad value |
| fn_alt2_oe | input | 32 | Second alternate drive enable |
| pad_out | output | 32 | Value driven to pads |
| pad_oe | output | 32 | Drive enable to pads |
| pad_in | input | 32 | Value sampled from pads |
| fn_main_in | output | 32 | Main function input |
| fn_alt1_in | output | 32 | First alternate input |
| fn_alt2_in | output | 32 | Second alternate input |
| fn_alt3_in | output | 32 | Third alternate input |

## Verification
The hardest case to reach is a pad input passed through all three sample stages. Proving that every unselected leg carries its own stage's default, and not a neighbour's, needs the two default words and the three select words to disagree in different bits at once. The stimulus writes select and default masks with staggered bit patterns and drives the pad input with a pattern that differs from both defaults. Each of the eight combinations of the three select bits then appears on several pads in one pass.

// File: rtl/pinmux_pkg.sv
package pinmux_pkg;
  localparam int unsigned NUM_WORDS = 9;

  typedef enum logic [3:0] {
    W_M_INSEL   = 4'd0,
    W_M_OUTSEL  = 4'd1,
    W_M_OENSEL  = 4'd2,
    W_M_DFLT    = 4'd3,
    W_A1_INSEL  = 4'd4,
    W_A1_OUTSEL = 4'd5,
    W_A1_OENSEL = 4'd6,
    W_A1_DFLT   = 4'd7,
    W_A2_INSEL  = 4'd8
  } word_e;

  // byte address of each stored word
  function automatic logic [11:0] word_addr(input int unsigned idx);
    case (idx)
      0:       return 12'h868;
      1:       return 12'h870;
      2:       return 12'h878;
      3:       return 12'h088;
      4:       return 12'h888;
      5:       return 12'h890;
      6:       return 12'h898;
      7:       return 12'h8A0;
      default: return 12'h8A8;
    endcase
  endfunction
endpackage

// File: rtl/pinmux_regs.sv
module pinmux_regs
  import pinmux_pkg::*;
#(
  parameter int unsigned NUM_PADS = 32,
  parameter int unsigned ADDR_W   = 12
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic                                 wr_en,
  input  logic [ADDR_W-1:0]                    addr,
  input  logic [NUM_PADS-1:0]                  wdata,
  output logic [NUM_PADS-1:0]                  rdata,
  output logic [NUM_WORDS-1:0][NUM_PADS-1:0]   words
);

  logic [NUM_WORDS-1:0][NUM_PADS-1:0] word_q;
  logic [NUM_WORDS-1:0]               hit;
  logic [NUM_PADS-1:0]                rd_nxt;
  logic [NUM_PADS-1:0]                rd_q;
  logic                               mapped;

  for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
    assign hit[w] = (addr == ADDR_W'(word_addr(w)));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        word_q[w] <= '0;
      end else if (wr_en && hit[w]) begin
        word_q[w] <= wdata;
      end
    end

    // R9: a mapped write lands in its own word
    a_r9_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && hit[w]) |=> (words[w] == $past(wdata)));
  end

  assign mapped = |hit;

  always_comb begin
    rd_nxt = '0;
    for (int w = 0; w < NUM_WORDS; w++) begin
      if (hit[w]) rd_nxt = word_q[w];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_q <= '0;
    else        rd_q <= rd_nxt;
  end

  assign rdata = rd_q;
  assign words = word_q;

  // R10: unmapped reads return zero
  a_r10_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !mapped |=> (rdata == '0));

  // R10: unmapped write leaves storage untouched
  a_r10_unmapped_wr_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !mapped) |=> $stable(words));

endmodule

// File: rtl/pinmux_sel2.sv
module pinmux_sel2 #(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] sel,
  input  logic [W-1:0] leg0,
  input  logic [W-1:0] leg1,
  output logic [W-1:0] y
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    assign y[i] = sel[i] ? leg1[i] : leg0[i];
  end
endmodule

// File: rtl/pinmux_split2.sv
module pinmux_split2 #(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] sel,
  input  logic [W-1:0] din,
  input  logic [W-1:0] dflt,
  output logic [W-1:0] near,
  output logic [W-1:0] far
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    assign near[i] = sel[i] ? dflt[i] : din[i];
    assign far[i]  = sel[i] ? din[i]  : dflt[i];
  end
endmodule

// File: rtl/pinmux_cascade.sv
module pinmux_cascade
  import pinmux_pkg::*;
#(
  parameter int unsigned NUM_PADS = 32,
  parameter int unsigned ADDR_W   = 12
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                reg_wr,
  input  logic [ADDR_W-1:0]   reg_addr,
  input  logic [NUM_PADS-1:0] reg_wdata,
  output logic [NUM_PADS-1:0] reg_rdata,
  input  logic [NUM_PADS-1:0] fn_main_out,
  input  logic [NUM_PADS-1:0] fn_main_oe,
  input  logic [NUM_PADS-1:0] fn_alt1_out,
  input  logic [NUM_PADS-1:0] fn_alt1_oe,
  input  logic [NUM_PADS-1:0] fn_alt2_out,
  input  logic [NUM_PADS-1:0] fn_alt2_oe,
  output logic [NUM_PADS-1:0] pad_out,
  output logic [NUM_PADS-1:0] pad_oe,
  input  logic [NUM_PADS-1:0] pad_in,
  output logic [NUM_PADS-1:0] fn_main_in,
  output logic [NUM_PADS-1:0] fn_alt1_in,
  output logic [NUM_PADS-1:0] fn_alt2_in,
  output logic [NUM_PADS-1:0] fn_alt3_in
);

  logic [NUM_WORDS-1:0][NUM_PADS-1:0] words;
  logic [NUM_PADS-1:0] a1_out_res, a1_oe_res;
  logic [NUM_PADS-1:0] leg_m2a1, leg_a12a2;
  logic [NUM_PADS-1:0] tie_low;

  assign tie_low = '0;

  pinmux_regs #(.NUM_PADS(NUM_PADS), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_wr), .addr(reg_addr),
    .wdata(reg_wdata), .rdata(reg_rdata), .words(words)
  );

  // drive path: alt1 stage then main stage
  pinmux_sel2 #(.W(NUM_PADS)) u_out_a1 (
    .sel(words[W_A1_OUTSEL]), .leg0(fn_alt1_out), .leg1(fn_alt2_out), .y(a1_out_res));
  pinmux_sel2 #(.W(NUM_PADS)) u_out_m (
    .sel(words[W_M_OUTSEL]), .leg0(fn_main_out), .leg1(a1_out_res), .y(pad_out));

  // enable path
  pinmux_sel2 #(.W(NUM_PADS)) u_oe_a1 (
    .sel(words[W_A1_OENSEL]), .leg0(fn_alt1_oe), .leg1(fn_alt2_oe), .y(a1_oe_res));
  pinmux_sel2 #(.W(NUM_PADS)) u_oe_m (
    .sel(words[W_M_OENSEL]), .leg0(fn_main_oe), .leg1(a1_oe_res), .y(pad_oe));

  // sample path: main -> alt1 -> alt2/alt3
  pinmux_split2 #(.W(NUM_PADS)) u_in_m (
    .sel(words[W_M_INSEL]), .din(pad_in), .dflt(words[W_M_DFLT]),
    .near(fn_main_in), .far(leg_m2a1));
  pinmux_split2 #(.W(NUM_PADS)) u_in_a1 (
    .sel(words[W_A1_INSEL]), .din(leg_m2a1), .dflt(words[W_A1_DFLT]),
    .near(fn_alt1_in), .far(leg_a12a2));
  pinmux_split2 #(.W(NUM_PADS)) u_in_a2 (
    .sel(words[W_A2_INSEL]), .din(leg_a12a2), .dflt(tie_low),
    .near(fn_alt2_in), .far(fn_alt3_in));

  // R2: pads with main drive selected follow the main function
  a_r2_main_drive: assert property (@(posedge clk) disable iff (!rst_n)
    ((~words[W_M_OUTSEL]) & (pad_out ^ fn_main_out)) == '0);

  // R3: pads on the full alternate chain follow the second alternate
  a_r3_alt2_drive: assert property (@(posedge clk) disable iff (!rst_n)
    (words[W_M_OUTSEL] & words[W_A1_OUTSEL] & (pad_out ^ fn_alt2_out)) == '0);

  // R4: enable routed through first alternate when main leg is off
  a_r4_alt1_enable: assert property (@(posedge clk) disable iff (!rst_n)
    (words[W_M_OENSEL] & ~words[W_A1_OENSEL] & (pad_oe ^ fn_alt1_oe)) == '0);

  // R5: main input gets its default when not selected
  a_r5_main_default: assert property (@(posedge clk) disable iff (!rst_n)
    (words[W_M_INSEL] & (fn_main_in ^ words[W_M_DFLT])) == '0);

  // R6: pad value reaches alt1 only when main passes it on and alt1 keeps it
  a_r6_alt1_pass: assert property (@(posedge clk) disable iff (!rst_n)
    (words[W_M_INSEL] & ~words[W_A1_INSEL] & (fn_alt1_in ^ pad_in)) == '0);

  // R7: alt2 and alt3 inputs are never both driven high
  a_r7_last_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    (fn_alt2_in & fn_alt3_in) == '0);

endmodule

// File: tb/pinmux_cascade_tb.sv
`timescale 1ns/1ps
module pinmux_cascade_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_wr;
  logic [11:0] reg_addr;
  logic [31:0] reg_wdata, reg_rdata;
  logic [31:0] m_out, m_oe, a1_out, a1_oe, a2_out, a2_oe;
  logic [31:0] pad_out, pad_oe, pad_in;
  logic [31:0] m_in, a1_in, a2_in, a3_in;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  // bench shadow of programmed words
  logic [31:0] s_m_insel, s_m_outsel, s_m_oensel, s_m_dflt;
  logic [31:0] s_a1_insel, s_a1_outsel, s_a1_oensel, s_a1_dflt, s_a2_insel;

  always #10 clk = ~clk;

  pinmux_cascade u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .fn_main_out(m_out), .fn_main_oe(m_oe), .fn_alt1_out(a1_out), .fn_alt1_oe(a1_oe),
    .fn_alt2_out(a2_out), .fn_alt2_oe(a2_oe), .pad_out(pad_out), .pad_oe(pad_oe),
    .pad_in(pad_in), .fn_main_in(m_in), .fn_alt1_in(a1_in), .fn_alt2_in(a2_in),
    .fn_alt3_in(a3_in)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    @(negedge clk);
    d = reg_rdata;
  endtask

  function automatic logic [31:0] mux(input logic [31:0] s, input logic [31:0] l0, input logic [31:0] l1);
    return (~s & l0) | (s & l1);
  endfunction

  task automatic check_routes(input string tag);
    logic [31:0] leg1, leg2;
    check({tag, " R2 pad_out"}, pad_out, mux(s_m_outsel, m_out, mux(s_a1_outsel, a1_out, a2_out)));
    check({tag, " R4 pad_oe"}, pad_oe, mux(s_m_oensel, m_oe, mux(s_a1_oensel, a1_oe, a2_oe)));
    leg1 = mux(s_m_insel, s_m_dflt, pad_in);
    check({tag, " R5 main_in"}, m_in, mux(s_m_insel, pad_in, s_m_dflt));
    leg2 = mux(s_a1_insel, s_a1_dflt, leg1);
    check({tag, " R6 alt1_in"}, a1_in, mux(s_a1_insel, leg1, s_a1_dflt));
    check({tag, " R7 alt2_in"}, a2_in, ~s_a2_insel & leg2);
    check({tag, " R7 alt3_in"}, a3_in, s_a2_insel & leg2);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    m_out = 32'hA5A5_0F0F; m_oe = 32'h1234_5678; a1_out = 32'hFFFF_0000;
    a1_oe = 32'h0F0F_F0F0; a2_out = 32'h3C3C_C3C3; a2_oe = 32'hDEAD_BEEF;
    pad_in = 32'h9876_5432;
    @(negedge clk);
    check("R1 rdata at reset", reg_rdata, 32'h0);
    check("R1 pad_out", pad_out, m_out);
    check("R1 pad_oe", pad_oe, m_oe);
    check("R1 main_in", m_in, pad_in);
    check("R1 alt1_in", a1_in, 32'h0);
    check("R1 alt2_in", a2_in, 32'h0);
    check("R1 alt3_in", a3_in, 32'h0);
    for (int w = 0; w < 9; w++) begin
      rd(pinmux_pkg::word_addr(w), d);
      check("R1 word reset", d, 32'h0);
    end
  endtask

  task automatic t_drive();
    s_m_outsel = 32'hFFFF_0000; s_a1_outsel = 32'hFF00_FF00;
    s_m_oensel = 32'hF0F0_F0F0; s_a1_oensel = 32'hCCCC_CCCC;
    wr(12'h870, s_m_outsel); wr(12'h890, s_a1_outsel);
    wr(12'h878, s_m_oensel); wr(12'h898, s_a1_oensel);
    @(negedge clk);
    check_routes("drive-a R3");
    m_out = ~m_out; a1_out = 32'h0123_4567; a2_out = 32'h89AB_CDEF;
    a1_oe = ~a1_oe; a2_oe = 32'h5555_AAAA;
    #1;
    check_routes("drive-b R3");
  endtask

  task automatic t_sample();
    s_m_insel = 32'hAAAA_AAAA; s_m_dflt = 32'h0000_FFFF;
    s_a1_insel = 32'hCCCC_CCCC; s_a1_dflt = 32'h00FF_00FF;
    s_a2_insel = 32'hF0F0_F0F0;
    wr(12'h868, s_m_insel); wr(12'h088, s_m_dflt);
    wr(12'h888, s_a1_insel); wr(12'h8A0, s_a1_dflt); wr(12'h8A8, s_a2_insel);
    @(negedge clk);
    check_routes("sample-a R5 R6 R7");
    pad_in = ~pad_in; #1;
    check_routes("sample-b R5 R6 R7");
    pad_in = 32'hFFFF_FFFF; #1;
    check_routes("sample-c R6 defaults");
  endtask

  task automatic t_timing();
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = 12'h870; reg_wdata = ~s_m_outsel;
    #1;
    check("R9 before edge", pad_out, mux(s_m_outsel, m_out, mux(s_a1_outsel, a1_out, a2_out)));
    @(posedge clk); #1;
    reg_wr = 1'b0;
    s_m_outsel = ~s_m_outsel;
    check("R9 after edge", pad_out, mux(s_m_outsel, m_out, mux(s_a1_outsel, a1_out, a2_out)));
  endtask

  task automatic t_map();
    logic [31:0] d;
    for (int w = 0; w < 9; w++) wr(pinmux_pkg::word_addr(w), 32'h1111_1111 * (w + 1) ^ 32'h8000_0001);
    for (int w = 0; w < 9; w++) begin
      rd(pinmux_pkg::word_addr(w), d);
      check("R8 readback", d, 32'h1111_1111 * (w + 1) ^ 32'h8000_0001);
    end
  endtask

  task automatic t_unmapped();
    logic [31:0] d;
    wr(12'h880, 32'hFFFF_FFFF); wr(12'h000, 32'hFFFF_FFFF); wr(12'h8B0, 32'hFFFF_FFFF);
    rd(12'h880, d); check("R10 unmapped 0x880", d, 32'h0);
    rd(12'h8B0, d); check("R10 unmapped 0x8B0", d, 32'h0);
    for (int w = 0; w < 9; w++) begin
      rd(pinmux_pkg::word_addr(w), d);
      check("R10 mapped unchanged", d, 32'h1111_1111 * (w + 1) ^ 32'h8000_0001);
    end
  endtask

  initial begin
    s_m_insel = '0; s_m_outsel = '0; s_m_oensel = '0; s_m_dflt = '0;
    s_a1_insel = '0; s_a1_outsel = '0; s_a1_oensel = '0; s_a1_dflt = '0; s_a2_insel = '0;
    rst_n = 1'b0; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_drive();
    t_sample();
    t_timing();
    t_map();
    t_unmapped();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule